// File: doc/BRIEF.md
# Oversampled Serial Packet Receiver

This block takes in a single serial line from a remote acquisition module and turns it into 16-bit words. The remote module's bit clock is derived from the local clock, so the bit rate is known exactly and only the phase is unknown. The receiver runs 16 system clocks per bit. It treats a long stretch of the idle level as the boundary between packets. It finds the falling edge that opens each start bit, confirms the start bit at mid-bit, and then samples every bit at its centre. Every transition on the line pulls the sampling phase back into alignment, so small rate or phase errors do not build up across a word.

Each word on the line is framed as follows: a start bit at 0, then 16 data bits with the most significant bit first, then a stop bit at 1. In full-packet mode, a packet is 16 such words. In single-word mode, each reply is one word and is a complete transfer by itself. Every received word appears for one clock on a valid/data output pair. The word that closes a packet also raises a done flag in the same clock. A bad stop bit raises an error flag and discards the rest of the packet.

Top module: `osr_pkt_rx`

## Requirements
- R1: After reset, and after a framing error, no start bit is accepted until the line has stayed at 1 for more than 80 consecutive bit times (each bit time is 16 clocks). Words sent before that produce neither `word_valid` nor `frame_err`.
- R2: A start is a 1-to-0 transition on the line. The line is sampled 8 clocks later. If it reads 1 at that point, the event is discarded without any output, and the receiver goes back to looking for a start edge.
- R3: Each accepted word is made of 16 data bits, most significant first. It appears on `word_data` together with a `word_valid` pulse one clock wide.
- R4: Every transition seen while a word is being received moves the next sample point to 8 clocks after that transition. As a result, words whose bits alternate are received correctly at bit periods of 15 and 17 clocks.
- R5: Data bits with no transitions between them are sampled every 16 clocks, so words of all zeros and all ones are received correctly.
- R6: When `single_mode` is 0, `packet_done` pulses only with the 16th word of a packet. The word count then starts again from zero.
- R7: When `single_mode` is 1, every accepted word comes with a `packet_done` pulse.
- R8: If the stop bit samples as 0, `frame_err` pulses for one clock and that word is not output. The packet's word count is cleared, and R1 applies again.
- R9: While reset is asserted, and in the clock after it, `word_valid`, `packet_done` and `frame_err` are all 0.
- R10: Once a word has finished without error, the next start edge is accepted at once, with no idle period needed, whether it is within a packet or at the start of a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 16 per bit |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Serial line from the remote module, idle at 1 |
| single_mode | input | 1 | 1 selects one word per transfer, 0 selects 16-word packets |
| word_valid | output | 1 | One-clock pulse when `word_data` holds a new word |
| word_data | output | 16 | Received word |
| packet_done | output | 1 | Pulses together with the word that closes a transfer |
| frame_err | output | 1 | One-clock pulse when a stop bit is missing |

## Verification
Random 16-word packets with random gaps of zero to two bits test framing, bit order, the packet-length count and back-to-back acceptance. All-zero and all-one words are run at the exact rate to check that the phase holds when there are no edges. Alternating words at periods of 15 and 17 clocks separate a design that re-aligns on every edge from one that aligns only on the start bit, because the error in the second case grows past half a bit. A short low glitch, a word sent during too short an idle, and a word with a bad stop bit test start confirmation, the idle gate and the abort path.

// File: rtl/osr_pkg.sv
package osr_pkg;
  typedef enum logic [2:0] {
    S_WAIT_IDLE,
    S_HUNT,
    S_START,
    S_DATA,
    S_STOP
  } rx_state_t;
endpackage

// File: rtl/osr_line_sync.sv
module osr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_s,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign line_s = sync_q[STAGES-1];
  assign rise   = line_s & ~prev_q;
  assign fall   = ~line_s & prev_q;
endmodule

// File: rtl/osr_bit_timer.sv
module osr_bit_timer #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic resync,
  output logic sample_stb
);
  localparam int CW   = (OSR > 2) ? $clog2(OSR) : 1;
  localparam int HALF = OSR / 2;

  logic [CW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (resync) begin
      phase_q <= CW'(1);
    end else if (run) begin
      phase_q <= (phase_q == CW'(OSR - 1)) ? '0 : phase_q + CW'(1);
    end else begin
      phase_q <= '0;
    end
  end

  assign sample_stb = run & ~resync & (phase_q == CW'(HALF));
endmodule

// File: rtl/osr_idle_watch.sv
module osr_idle_watch #(
  parameter int OSR       = 16,
  parameter int IDLE_BITS = 80
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic line_s,
  output logic idle_full
);
  localparam int IDLE_CLKS = (IDLE_BITS + 1) * OSR;
  localparam int IW        = $clog2(IDLE_CLKS + 1);

  logic [IW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || clr || !line_s) begin
      run_q <= '0;
    end else if (run_q != IW'(IDLE_CLKS)) begin
      run_q <= run_q + IW'(1);
    end
  end

  assign idle_full = (run_q == IW'(IDLE_CLKS));
endmodule

// File: rtl/osr_pkt_rx.sv
module osr_pkt_rx
  import osr_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int WORD_W    = 16,
  parameter int PKT_WORDS = 16,
  parameter int IDLE_BITS = 80,
  parameter int SYNC_FF   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_line,
  input  logic              single_mode,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic              packet_done,
  output logic              frame_err
);
  localparam int BW = $clog2(WORD_W);
  localparam int PW = (PKT_WORDS > 1) ? $clog2(PKT_WORDS) : 1;

  rx_state_t        state_q;
  logic [BW-1:0]    bit_q;
  logic [PW-1:0]    wcnt_q;
  logic [WORD_W-1:0] shift_q;

  logic line_s, rise, fall, stb, idle_full;
  logic busy, tmr_sync, idle_clr, stop_bad;

  osr_line_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk(clk), .rst(rst), .line_in(rx_line),
    .line_s(line_s), .rise(rise), .fall(fall)
  );

  assign busy     = (state_q == S_START) || (state_q == S_DATA) || (state_q == S_STOP);
  assign tmr_sync = ((state_q == S_HUNT) & fall) | (busy & (rise | fall));
  assign stop_bad = (state_q == S_STOP) & stb & ~line_s;
  assign idle_clr = stop_bad;

  osr_bit_timer #(.OSR(OSR)) u_timer (
    .clk(clk), .rst(rst), .run(busy), .resync(tmr_sync), .sample_stb(stb)
  );

  osr_idle_watch #(.OSR(OSR), .IDLE_BITS(IDLE_BITS)) u_idle (
    .clk(clk), .rst(rst), .clr(idle_clr), .line_s(line_s), .idle_full(idle_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_WAIT_IDLE;
      bit_q       <= '0;
      wcnt_q      <= '0;
      shift_q     <= '0;
      word_valid  <= 1'b0;
      word_data   <= '0;
      packet_done <= 1'b0;
      frame_err   <= 1'b0;
    end else begin
      word_valid  <= 1'b0;
      packet_done <= 1'b0;
      frame_err   <= 1'b0;
      unique case (state_q)
        S_WAIT_IDLE: begin
          wcnt_q <= '0;
          if (idle_full) state_q <= S_HUNT;
        end
        S_HUNT: begin
          if (fall) state_q <= S_START;
        end
        S_START: begin
          if (stb) begin
            if (!line_s) begin
              state_q <= S_DATA;
              bit_q   <= '0;
            end else begin
              state_q <= S_HUNT;
            end
          end
        end
        S_DATA: begin
          if (stb) begin
            shift_q <= {shift_q[WORD_W-2:0], line_s};
            bit_q   <= bit_q + BW'(1);
            if (bit_q == BW'(WORD_W - 1)) state_q <= S_STOP;
          end
        end
        S_STOP: begin
          if (stb) begin
            if (line_s) begin
              word_valid <= 1'b1;
              word_data  <= shift_q;
              state_q    <= S_HUNT;
              if (single_mode || wcnt_q == PW'(PKT_WORDS - 1)) begin
                packet_done <= 1'b1;
                wcnt_q      <= '0;
              end else begin
                wcnt_q <= wcnt_q + PW'(1);
              end
            end else begin
              frame_err <= 1'b1;
              wcnt_q    <= '0;
              state_q   <= S_WAIT_IDLE;
            end
          end
        end
        default: state_q <= S_WAIT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/osr_pkt_rx_chk.sv
module osr_pkt_rx_chk #(
  parameter int PKT_WORDS = 16
) (
  input logic clk,
  input logic rst,
  input logic single_mode,
  input logic word_valid,
  input logic packet_done,
  input logic frame_err,
  input logic in_wait_idle
);
  localparam int CW = $clog2(PKT_WORDS + 1);
  logic [CW-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst || packet_done || frame_err) seen_q <= '0;
    else if (word_valid) seen_q <= seen_q + CW'(1);
  end

  // R1
  gate_closed_chk: assert property (@(posedge clk) disable iff (rst)
    in_wait_idle |-> !word_valid);
  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);
  // R6
  full_count_chk: assert property (@(posedge clk) disable iff (rst)
    (packet_done && !single_mode) |-> (seen_q == CW'(PKT_WORDS - 1)));
  // R7
  single_done_chk: assert property (@(posedge clk) disable iff (rst)
    (word_valid && single_mode) |-> packet_done);
  // R7
  done_with_word_chk: assert property (@(posedge clk) disable iff (rst)
    packet_done |-> word_valid);
  // R8
  err_abort_chk: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> (!word_valid && in_wait_idle));
  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!word_valid && !packet_done && !frame_err));
endmodule

bind osr_pkt_rx osr_pkt_rx_chk #(.PKT_WORDS(PKT_WORDS)) u_chk (
  .clk(clk), .rst(rst), .single_mode(single_mode),
  .word_valid(word_valid), .packet_done(packet_done), .frame_err(frame_err),
  .in_wait_idle(state_q == osr_pkg::S_WAIT_IDLE)
);

// File: tb/osr_pkt_rx_bench.sv
module osr_pkt_rx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_line = 1'b1;
  logic        single_mode = 1'b0;
  logic        word_valid, packet_done, frame_err;
  logic [15:0] word_data;

  int checks = 0;
  int errors = 0;
  int cap_n = 0;
  int err_n = 0;
  int exp_n = 0;
  logic [15:0] cap_w [0:255];
  logic        cap_d [0:255];
  logic [15:0] exp_w [0:255];
  logic        exp_d [0:255];

  always #5 clk = ~clk;

  osr_pkt_rx u_osr_pkt_rx (
    .clk(clk), .rst(rst), .rx_line(rx_line), .single_mode(single_mode),
    .word_valid(word_valid), .word_data(word_data),
    .packet_done(packet_done), .frame_err(frame_err)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (word_valid && cap_n < 256) begin
        cap_w[cap_n] = word_data;
        cap_d[cap_n] = packet_done;
        cap_n++;
      end
      if (frame_err) err_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input int per);
    for (int i = 0; i < per; i++) begin
      @(negedge clk);
      rx_line = b;
    end
  endtask

  task automatic idle_bits(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1, 16);
  endtask

  task automatic send_word(input logic [15:0] w, input int per, input logic stop);
    send_bit(1'b0, per);
    for (int i = 15; i >= 0; i--) send_bit(w[i], per);
    send_bit(stop, per);
  endtask

  function automatic void expect_word(input logic [15:0] w, input logic d);
    exp_w[exp_n] = w;
    exp_d[exp_n] = d;
    exp_n++;
  endfunction

  task automatic compare(input string req);
    chk(cap_n == exp_n, {req, " word count"}, cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      chk(cap_w[i] == exp_w[i], {req, " data"}, cap_w[i], exp_w[i]);
      chk(cap_d[i] == exp_d[i], {req, " done flag"}, cap_d[i], exp_d[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] w;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    // R9 outputs quiet during reset
    chk(!word_valid && !packet_done && !frame_err, "R9", {word_valid, packet_done, frame_err}, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!word_valid && !packet_done && !frame_err, "R9", {word_valid, packet_done, frame_err}, 0);

    // R1 too little idle after reset: word ignored
    idle_bits(40);
    send_word(16'h1234, 16, 1'b1);
    idle_bits(2);
    chk(cap_n == 0, "R1 word before idle", cap_n, 0);
    chk(err_n == 0, "R1 no error before idle", err_n, 0);

    // R3 R5 R6 R10 random full packet with all-zero and all-one words
    idle_bits(90);
    for (int k = 0; k < 16; k++) begin
      w = (k == 3) ? 16'h0000 : (k == 4) ? 16'hFFFF : 16'($urandom);
      send_word(w, 16, 1'b1);
      expect_word(w, k == 15);
      idle_bits(int'($urandom_range(0, 2)));
    end
    idle_bits(2);
    compare("R3 R5 R6");

    // R10 second packet right after the first, no long idle
    for (int k = 0; k < 16; k++) begin
      w = 16'($urandom);
      send_word(w, 16, 1'b1);
      expect_word(w, k == 15);
    end
    idle_bits(2);
    compare("R10 R6");

    // R4 R7 drifted bit periods in single mode
    single_mode = 1'b1;
    idle_bits(1);
    send_word(16'hAAAA, 17, 1'b1); expect_word(16'hAAAA, 1'b1); idle_bits(1);
    send_word(16'h5555, 17, 1'b1); expect_word(16'h5555, 1'b1); idle_bits(1);
    send_word(16'hAAAA, 15, 1'b1); expect_word(16'hAAAA, 1'b1); idle_bits(1);
    send_word(16'h5555, 15, 1'b1); expect_word(16'h5555, 1'b1); idle_bits(1);
    idle_bits(1);
    compare("R4 R7");

    // R2 short low glitch rejected without error
    send_bit(1'b0, 4);
    idle_bits(3);
    chk(cap_n == exp_n, "R2 glitch gives no word", cap_n, exp_n);
    chk(err_n == 0, "R2 glitch gives no error", err_n, 0);
    w = 16'($urandom);
    send_word(w, 16, 1'b1); expect_word(w, 1'b1);
    idle_bits(2);
    compare("R2 R7");

    // R8 missing stop bit aborts a full packet
    single_mode = 1'b0;
    for (int k = 0; k < 3; k++) begin
      w = 16'($urandom);
      send_word(w, 16, 1'b1); expect_word(w, 1'b0);
    end
    send_word(16'hC3C3, 16, 1'b0);
    idle_bits(5);
    chk(err_n == 1, "R8 frame error pulse", err_n, 1);
    compare("R8 bad word dropped");
    send_word(16'h0F0F, 16, 1'b1);
    idle_bits(2);
    chk(cap_n == exp_n, "R8 R1 word refused after error", cap_n, exp_n);
    chk(err_n == 1, "R8 no further error", err_n, 1);

    // R8 R6 word count restarted after abort
    idle_bits(90);
    for (int k = 0; k < 16; k++) begin
      w = 16'($urandom);
      send_word(w, 16, 1'b1); expect_word(w, k == 15);
    end
    idle_bits(2);
    compare("R8 R6 fresh packet");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule